// File: doc/BRIEF.md
# Multi-Policy Request Arbiter

This block chooses one winner among N requesters that compete for a single crossbar target port. It takes a request vector and returns a grant vector that has at most one bit set. Four selection policies are available: plain index order, a ranked order set by software, a rotating order, and a rotating order with per-requester burst allowances. A small writable table holds the policy, one rank for each requester and one weight for each requester. The policy can be changed while traffic is running.

The grant is a combinational function of the present requests and the stored state, so a requester sees its grant in the same cycle it asks. The rotation pointer and the credit counters change on the clock edge that ends a granted cycle. A lock input lets the current winner keep the port for a burst of several cycles. While the lock holds, the pointer and the credits do not move.

Top module: `mode_arbiter`

## Requirements
- R1: With mode value 0 (policy field at table address 0, bits [1:0]), the lowest-numbered active requester is granted.
- R2: With mode value 1, the active requester with the smallest rank value wins. Between equal ranks, the lower index wins.
- R3: With mode value 2, the search for a winner starts one position after the last granted requester and wraps around. After reset the last granted position is N-1, so requester 0 is tried first.
- R4: With mode value 3, each requester holds a credit count. Only requesters with non-zero credit are eligible. The search starts at the last granted requester itself, so that requester can win again while its credit lasts. A weight of 0 acts as 1.
- R5: With mode value 3, every credit is set back to its weight in two cases: when no active requester has credit left (the search then starts one after the last winner), or when the winner's index is below the last winner's index. The winner's credit is then reduced by one.
- R6: When lock is high and the previous cycle's winner is still requesting, that grant is repeated. The pointer and the credits stay unchanged. If the previous winner has dropped its request, the lock has no effect.
- R7: The grant has at most one bit set, is a subset of the requests, is all-zero exactly when no request is present, and follows the requests in the same cycle.
- R8: A write with cfg_we at address 0 sets the mode from data bits [1:0]. A write at address 1+i sets requester i's rank from data bits [IW-1:0] and its weight from bits [IW+WW-1:IW]. A write takes effect from the next cycle. Reset restores mode 0, rank i for requester i, and weight 1 and credit 1 for every requester.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | N | Request vector, one bit per requester |
| lock | input | 1 | Keep the current grant for a burst |
| cfg_we | input | 1 | Table write strobe |
| cfg_addr | input | AW | Table address: 0 for mode, 1+i for requester i |
| cfg_wdata | input | IW+WW | Table write data |
| gnt | output | N | Grant vector, one-hot or zero |

## Verification
The bench first uses all-requesting, sparse and single-bit request vectors in index order. It then repeats them under a rank table in which ranks and indices disagree, which shows whether ranks are really used and how ties are broken. In rotating mode, patterns with gaps show whether the search starts after the last winner and not at the winner itself. Two-requester and alternating patterns in weighted mode separate repeat grants within the credit budget from the two different reload triggers. Lock sequences, with the holder still requesting and after it has dropped out, show that holding freezes the pointer and the credits. A sweep over every request value checks the one-hot rule, and a reset in the middle of the run shows the table returning to its defaults.

// File: rtl/mode_arbiter.sv
module mode_arbiter #(
  parameter int N  = 4,
  parameter int WW = 3,
  localparam int IW = (N > 1) ? $clog2(N) : 1,
  localparam int DW = IW + WW,
  localparam int AW = $clog2(N + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [N-1:0]  req,
  input  logic          lock,
  input  logic          cfg_we,
  input  logic [AW-1:0] cfg_addr,
  input  logic [DW-1:0] cfg_wdata,
  output logic [N-1:0]  gnt
);

  logic [1:0]    mode_q;
  logic [IW-1:0] rank_q [N];
  logic [WW-1:0] wgt_q  [N];
  logic [WW-1:0] cred_q [N];
  logic [IW-1:0] ptr_q;
  logic [N-1:0]  prev_q;

  logic [N-1:0]  elig, pick;
  logic [IW-1:0] k;
  logic          hold, starve, wrap;

  function automatic logic [N-1:0] rot_pick(input logic [N-1:0] s, input int st);
    logic [N-1:0] r;
    r = '0;
    for (int o = N - 1; o >= 0; o--) begin
      if (s[(st + o) % N]) begin
        r = '0;
        r[(st + o) % N] = 1'b1;
      end
    end
    return r;
  endfunction

  function automatic logic [IW-1:0] enc(input logic [N-1:0] oh);
    logic [IW-1:0] r;
    r = '0;
    for (int i = 0; i < N; i++)
      if (oh[i]) r = IW'(i);
    return r;
  endfunction

  function automatic logic [WW-1:0] weff(input logic [WW-1:0] w);
    return (w == '0) ? WW'(1) : w;
  endfunction

  always_comb
    for (int i = 0; i < N; i++) elig[i] = req[i] && (cred_q[i] != '0);

  assign hold   = lock && |(prev_q & req);
  assign starve = ~|elig;

  always_comb begin
    logic          found;
    logic [IW-1:0] best;
    pick  = '0;
    found = 1'b0;
    best  = '0;
    unique case (mode_q)
      2'd0: pick = req & (~req + 1'b1);
      2'd1:
        for (int i = 0; i < N; i++)
          if (req[i] && (!found || rank_q[i] < best)) begin
            pick     = '0;
            pick[i]  = 1'b1;
            best     = rank_q[i];
            found    = 1'b1;
          end
      2'd2: pick = rot_pick(req, int'(ptr_q) + 1);
      default: pick = starve ? rot_pick(req, int'(ptr_q) + 1) : rot_pick(elig, int'(ptr_q));
    endcase
  end

  assign k    = enc(pick);
  assign wrap = k < ptr_q;
  assign gnt  = hold ? prev_q : pick;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q <= 2'd0;
      ptr_q  <= IW'(N - 1);
      prev_q <= '0;
      for (int i = 0; i < N; i++) begin
        rank_q[i] <= IW'(i);
        wgt_q[i]  <= WW'(1);
        cred_q[i] <= WW'(1);
      end
    end else begin
      prev_q <= gnt;
      if (!hold && |req) begin
        ptr_q <= k;
        if (mode_q == 2'd3)
          for (int i = 0; i < N; i++) begin
            logic [WW-1:0] base;
            base = (starve || wrap) ? weff(wgt_q[i]) : cred_q[i];
            cred_q[i] <= (IW'(i) == k) ? base - WW'(1) : base;
          end
      end
      if (cfg_we) begin
        if (cfg_addr == '0) mode_q <= cfg_wdata[1:0];
        for (int i = 0; i < N; i++)
          if (cfg_addr == AW'(i + 1)) begin
            rank_q[i] <= cfg_wdata[IW-1:0];
            wgt_q[i]  <= cfg_wdata[DW-1:IW];
          end
      end
    end
  end

endmodule

module mode_arbiter_chk #(parameter int N = 4) (
  input logic         clk,
  input logic         rst_n,
  input logic [N-1:0] req,
  input logic         lock,
  input logic [N-1:0] gnt,
  input logic [1:0]   mode
);
  p_onehot_r7: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(gnt));
  p_subset_r7: assert property (@(posedge clk) disable iff (!rst_n) (gnt & ~req) == '0);
  p_idle_r7:   assert property (@(posedge clk) disable iff (!rst_n) (gnt == '0) == (req == '0));
  p_static_r1: assert property (@(posedge clk) disable iff (!rst_n)
                 (mode == 2'd0 && !lock) |-> gnt == (req & (~req + 1'b1)));
  p_hold_r6:   assert property (@(posedge clk) disable iff (!rst_n)
                 ($past(rst_n) && lock && |($past(gnt) & req)) |-> gnt == $past(gnt));
endmodule

bind mode_arbiter mode_arbiter_chk #(.N(N)) chk_i (
  .clk(clk), .rst_n(rst_n), .req(req), .lock(lock), .gnt(gnt), .mode(mode_q)
);

// File: tb/mode_arbiter_tb_top.sv
module mode_arbiter_tb_top;
  localparam int N = 4, WW = 3, IW = 2, DW = 5, AW = 3;
  localparam int NV = 40;
  // entry: {we, addr[2:0], wdata[4:0], lock, req[3:0], exp[3:0], tag[3:0]}
  localparam logic [21:0] VEC [NV] = '{
    {1'b0,3'd0,5'd0, 1'b0,4'b0110,4'b0010,4'd1},  // R1 lowest index
    {1'b0,3'd0,5'd0, 1'b0,4'b1000,4'b1000,4'd1},  // R1
    {1'b0,3'd0,5'd0, 1'b0,4'b1111,4'b0001,4'd1},  // R1
    {1'b1,3'd1,5'd7, 1'b0,4'b0011,4'b0001,4'd1},  // R1 rank0=3
    {1'b1,3'd2,5'd6, 1'b0,4'b0011,4'b0001,4'd8},  // R8 rank1=2
    {1'b1,3'd3,5'd5, 1'b0,4'b0000,4'b0000,4'd7},  // R7 rank2=1
    {1'b1,3'd4,5'd7, 1'b0,4'b0000,4'b0000,4'd7},  // R7 rank3=3
    {1'b1,3'd0,5'd1, 1'b0,4'b0001,4'b0001,4'd8},  // R8 mode1 next cycle
    {1'b0,3'd0,5'd0, 1'b0,4'b1111,4'b0100,4'd2},  // R2
    {1'b0,3'd0,5'd0, 1'b0,4'b1011,4'b0010,4'd2},  // R2
    {1'b0,3'd0,5'd0, 1'b0,4'b1001,4'b0001,4'd2},  // R2 tie
    {1'b1,3'd0,5'd2, 1'b0,4'b1000,4'b1000,4'd2},  // R2, mode2 next
    {1'b0,3'd0,5'd0, 1'b0,4'b1111,4'b0001,4'd3},  // R3
    {1'b0,3'd0,5'd0, 1'b0,4'b1111,4'b0010,4'd3},  // R3
    {1'b0,3'd0,5'd0, 1'b0,4'b1111,4'b0100,4'd3},  // R3
    {1'b0,3'd0,5'd0, 1'b0,4'b1011,4'b1000,4'd3},  // R3
    {1'b0,3'd0,5'd0, 1'b0,4'b1010,4'b0010,4'd3},  // R3 wrap
    {1'b0,3'd0,5'd0, 1'b1,4'b1110,4'b0010,4'd6},  // R6 hold
    {1'b0,3'd0,5'd0, 1'b1,4'b1110,4'b0010,4'd6},  // R6 hold
    {1'b0,3'd0,5'd0, 1'b0,4'b1110,4'b0100,4'd6},  // R6 pointer frozen
    {1'b0,3'd0,5'd0, 1'b1,4'b1010,4'b1000,4'd6},  // R6 holder dropped
    {1'b1,3'd1,5'd11,1'b0,4'b0000,4'b0000,4'd8},  // R8 w0=2
    {1'b1,3'd2,5'd2, 1'b0,4'b0000,4'b0000,4'd8},  // R8 w1=0
    {1'b1,3'd0,5'd3, 1'b0,4'b0000,4'b0000,4'd8},  // R8 mode3
    {1'b0,3'd0,5'd0, 1'b0,4'b0011,4'b0001,4'd4},  // R4
    {1'b0,3'd0,5'd0, 1'b0,4'b0011,4'b0001,4'd4},  // R4 second grant
    {1'b0,3'd0,5'd0, 1'b0,4'b0011,4'b0010,4'd4},  // R4
    {1'b0,3'd0,5'd0, 1'b0,4'b0011,4'b0001,4'd5},  // R5 starve reload
    {1'b0,3'd0,5'd0, 1'b0,4'b0011,4'b0001,4'd4},  // R4
    {1'b0,3'd0,5'd0, 1'b0,4'b0011,4'b0010,4'd4},  // R4 weight 0 as 1
    {1'b0,3'd0,5'd0, 1'b0,4'b0101,4'b0100,4'd4},  // R4
    {1'b0,3'd0,5'd0, 1'b0,4'b0101,4'b0001,4'd5},  // R5
    {1'b0,3'd0,5'd0, 1'b0,4'b0101,4'b0001,4'd4},  // R4
    {1'b0,3'd0,5'd0, 1'b0,4'b0101,4'b0100,4'd4},  // R4
    {1'b0,3'd0,5'd0, 1'b0,4'b0010,4'b0010,4'd5},  // R5 wrap reload
    {1'b0,3'd0,5'd0, 1'b0,4'b0101,4'b0100,4'd5},  // R5
    {1'b0,3'd0,5'd0, 1'b1,4'b0101,4'b0100,4'd6},  // R6 hold in weighted
    {1'b0,3'd0,5'd0, 1'b0,4'b0101,4'b0001,4'd5},  // R5
    {1'b0,3'd0,5'd0, 1'b0,4'b0101,4'b0001,4'd4},  // R4
    {1'b0,3'd0,5'd0, 1'b0,4'b0101,4'b0100,4'd4}   // R4
  };

  logic          clk = 1'b0, rst_n = 1'b0, lock = 1'b0, cfg_we = 1'b0;
  logic [N-1:0]  req = '0;
  logic [AW-1:0] cfg_addr = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic [N-1:0]  gnt;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  mode_arbiter #(.N(N), .WW(WW)) dut_i (
    .clk(clk), .rst_n(rst_n), .req(req), .lock(lock), .cfg_we(cfg_we),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .gnt(gnt)
  );

  task automatic step(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic lk, input logic [N-1:0] r, input logic [N-1:0] exp,
                      input int tag);
    @(negedge clk);
    cfg_we = we; cfg_addr = a; cfg_wdata = d; lock = lk; req = r;
    #1;
    checks++;
    if (gnt !== exp) begin
      errors++;
      $display("FAIL R%0d: req=%b gnt=%b expected %b", tag, r, gnt, exp);
    end
  endtask

  initial begin
    #1000000;
    errors++; checks++;
    $display("FAIL watchdog: run did not finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    step(1'b0, '0, '0, 1'b0, 4'b0000, 4'b0000, 7);  // R7 idle after reset
    for (int s = 0; s < NV; s++)
      step(VEC[s][21], VEC[s][20:18], VEC[s][17:13], VEC[s][12], VEC[s][11:8],
           VEC[s][7:4], int'(VEC[s][3:0]));
    // mid-run reset restores defaults (R8) and pointer (R3)
    @(negedge clk); rst_n = 1'b0; cfg_we = 1'b0; lock = 1'b0; req = '0;
    @(negedge clk); rst_n = 1'b1;
    step(1'b1, 3'd0, 5'd2, 1'b0, 4'b0000, 4'b0000, 7);
    step(1'b0, 3'd0, 5'd0, 1'b0, 4'b1111, 4'b0001, 3);  // R3 starts at 0
    step(1'b1, 3'd0, 5'd1, 1'b0, 4'b0000, 4'b0000, 7);
    step(1'b0, 3'd0, 5'd0, 1'b0, 4'b0101, 4'b0001, 8);  // R8 ranks back to index
    step(1'b1, 3'd0, 5'd0, 1'b0, 4'b0000, 4'b0000, 7);
    step(1'b0, 3'd0, 5'd0, 1'b0, 4'b1100, 4'b0100, 1);  // R1 after reset
    // R7 sweep of every request value under static order
    for (int r = 1; r < 16; r++) begin
      logic [N-1:0] e;
      e = '0;
      for (int b = N - 1; b >= 0; b--) if (r[b]) e = N'(1) << b;
      step(1'b0, 3'd0, 5'd0, 1'b0, N'(r), e, 7);
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule